// File: doc/BRIEF.md
# Variable-Width FIFO SPI Master

This block is an SPI bus master driven through a small 32-bit word-addressed register port. Software queues transmit entries into a four-deep TX FIFO; each entry carries a left-aligned payload of up to 24 bits and, in variable-width mode, its own shift length in the top byte. A single shift engine takes entries one at a time, clocks them out MSB-first on `spi_mosi` at a rate set by a programmable divider, and captures the same number of bits from `spi_miso` into a four-deep RX FIFO. Clock polarity and the launch and capture phases are chosen independently.

Entries can be queued through two ports. An entry written to the data port releases chip-select when it finishes and nothing else is queued. An entry written to the hold port keeps chip-select low, so several entries form one frame. One idle SCLK period is inserted after every entry. An interrupt line combines a TX-empty source and an idle source, each with its own enable.

The register port has no back-pressure. A write or read strobe completes in the cycle it is presented. A write to a full TX FIFO is discarded. A read of an empty RX FIFO returns zero and changes nothing. Register word indices are: 0 control A, 1 control B, 2 status, 3 data port, 4 hold port.

Top module: `vws_spi_master`

## Requirements
- R1: A TX entry holds its payload in bits 23:0, and bit 23 is sent first. When control A bit 14 is set, bits 31:24 of the entry give its length. Otherwise control A bits 5:0 give the length. A length of 0 or above 24 is treated as 24.
- R2: Control A bits 31:20 hold the speed value S. Every SCLK half period lasts S+1 system clocks. An entry of N bits produces exactly 2N SCLK transitions.
- R3: Between two back-to-back entries, SCLK stays at its idle level for one full SCLK period. The time from the last transition of one entry to the first transition of the next is therefore 3(S+1) clocks.
- R4: `spi_cs_n` is low whenever an entry is shifting. After a data-port entry completes with the TX FIFO empty, `spi_cs_n` goes high. After a hold-port entry completes, `spi_cs_n` stays low until a later data-port entry finishes.
- R5: SCLK idles at control A bit 7 (CPOL). Control A bit 8 selects the launch edge: 0 launches on the trailing edge, 1 on the leading edge. Control A bit 10 selects the capture edge: 0 captures on the leading edge, 1 on the trailing edge. With bits 8 and 10 equal, a looped-back MOSI is captured unchanged in all four modes.
- R6: The word received for an N-bit entry is placed in bits 23:0, with the first received bit at bit 23 and the low 24-N bits zero. A read of the data port returns the oldest RX word and pops it. A data-port read with the RX FIFO empty returns 0 and leaves the status unchanged.
- R7: Each FIFO holds 4 entries. A TX write while the FIFO is full is dropped. An RX word that arrives while the RX FIFO is full is dropped.
- R8: The status word has the TX level in bits 31:24 and the RX level in bits 23:16. Bit 10 is TX full, bit 9 TX empty, bit 8 RX full, bit 7 RX empty and bit 6 busy. Bits 5:0 give the bits still to shift in the current entry, or 0 when not shifting.
- R9: `irq` is high when control B bit 6 is set and the TX FIFO is empty, or when control B bit 7 is set and the shifter is not busy.
- R10: Writing control A with bit 9 set flushes both FIFOs. Control A bit 11 is the enable. While it is 0, the shifter stops at once, drops the partial entry and drives `spi_cs_n` high.
- R11: After reset, the status reads 0x00000280, `spi_cs_n` is 1, `spi_sclk` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on the data port) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip-select |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the entry-length corners: single-bit entries, full 24-bit entries, a zero length and an over-long length. A design that clamped wrongly would emit the wrong number of SCLK transitions, or return RX words with stray low bits. The gap between entries of a hold-port frame is measured exactly, because a shifter that skipped the idle period, or added a half period, would shift the next entry early or late. The bench also checks that `spi_cs_n` does not rise between a hold entry and a following data entry, and that it does rise after the data entry. It fills both FIFOs past capacity, reads an empty RX FIFO, and drops the enable in the middle of a transfer. A wrong level counter or a lingering chip-select shows up in the status word and on the pins.

// File: rtl/vws_pkg.sv
package vws_pkg;
  localparam int PAY_W = 24;
  localparam int LEN_W = 5;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_e;

  // register word indices
  localparam logic [2:0] A_CTLA = 3'd0;
  localparam logic [2:0] A_CTLB = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_HOLD = 3'd4;

  // control A field positions
  localparam int CA_FLEN_LSB = 0;
  localparam int CA_CPOL     = 7;
  localparam int CA_LAUNCH   = 8;
  localparam int CA_CLEAR    = 9;
  localparam int CA_CAPTURE  = 10;
  localparam int CA_EN       = 11;
  localparam int CA_VARLEN   = 14;
  localparam int CA_SPD_LSB  = 20;

  // control B field positions
  localparam int CB_TXE_IE  = 6;
  localparam int CB_IDLE_IE = 7;
endpackage

// File: rtl/vws_fifo.sv
module vws_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      level  <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      level  <= '0;
    end else begin
      if (do_push) wptr_q <= step(wptr_q);
      if (do_pop)  rptr_q <= step(rptr_q);
      level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (full && level == $past(level)));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/vws_shifter.sv
module vws_shifter
  import vws_pkg::*;
#(
  parameter int SPEED_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cpol,
  input  logic               launch_lead,
  input  logic               capture_trail,
  input  logic [SPEED_W-1:0] speed,
  input  logic               ent_valid,
  input  logic [PAY_W-1:0]   ent_data,
  input  logic [LEN_W-1:0]   ent_len,
  input  logic               ent_hold,
  output logic               ent_take,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               busy,
  output logic [5:0]         bits_left,
  output logic               rx_valid,
  output logic [PAY_W-1:0]   rx_word
);
  sh_state_e          state_q;
  logic [SPEED_W-1:0] div_q;
  logic               half_q, gap_q, hold_q;
  logic [LEN_W-1:0]   len_q, cnt_q;
  logic [PAY_W-1:0]   tx_q, rx_q;
  logic               tick, last_bit;

  assign tick     = (state_q != SH_IDLE) && (div_q == speed);
  assign last_bit = (LEN_W'(cnt_q + 1'b1) == len_q);
  assign ent_take = en && ent_valid &&
                    ((state_q == SH_IDLE) || (state_q == SH_GAP && tick && gap_q));

  assign sclk      = cpol ^ half_q;
  assign mosi      = tx_q[PAY_W-1];
  assign busy      = (state_q != SH_IDLE);
  assign bits_left = (state_q == SH_SHIFT) ? 6'(len_q - cnt_q) : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SH_IDLE;
      div_q    <= '0;
      half_q   <= 1'b0;
      gap_q    <= 1'b0;
      hold_q   <= 1'b0;
      len_q    <= '0;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      cs_n     <= 1'b1;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else if (!en) begin
      state_q  <= SH_IDLE;
      div_q    <= '0;
      half_q   <= 1'b0;
      gap_q    <= 1'b0;
      cs_n     <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      div_q    <= (state_q == SH_IDLE || tick) ? '0 : div_q + 1'b1;
      case (state_q)
        SH_SHIFT: if (tick) begin
          half_q <= !half_q;
          if (!half_q) begin
            // leading edge
            if (!capture_trail) rx_q <= {rx_q[PAY_W-2:0], miso};
            if (launch_lead && cnt_q != '0) tx_q <= tx_q << 1;
          end else begin
            // trailing edge
            if (capture_trail) rx_q <= {rx_q[PAY_W-2:0], miso};
            if (!launch_lead) tx_q <= tx_q << 1;
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) state_q <= SH_GAP;
          end
        end
        SH_GAP: if (tick) begin
          if (!gap_q) begin
            gap_q <= 1'b1;
          end else begin
            gap_q    <= 1'b0;
            rx_valid <= 1'b1;
            rx_word  <= rx_q << (LEN_W'(PAY_W) - len_q);
            state_q  <= SH_IDLE;
            cs_n     <= !hold_q;
          end
        end
        default: ;
      endcase
      if (ent_take) begin
        state_q <= SH_SHIFT;
        tx_q    <= ent_data;
        rx_q    <= '0;
        len_q   <= ent_len;
        hold_q  <= ent_hold;
        cnt_q   <= '0;
        half_q  <= 1'b0;
        gap_q   <= 1'b0;
        cs_n    <= 1'b0;
      end
    end
  end

  p_cs_in_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SHIFT) |-> !cs_n);

  p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(half_q) && $past(en)) |-> $past(tick));

  p_gap_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_GAP) |-> (sclk == cpol));
endmodule

// File: rtl/vws_spi_master.sv
module vws_spi_master
  import vws_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SPEED_W    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int TXE_W = 33;

  logic               en_q, cpol_q, launch_q, capture_q, varlen_q;
  logic [SPEED_W-1:0] speed_q;
  logic [5:0]         flen_q;
  logic               txe_ie_q, idle_ie_q;

  logic wr_ctla, wr_ctlb, tx_push, rx_pop, flush;
  assign wr_ctla = reg_wr && (reg_addr == A_CTLA);
  assign wr_ctlb = reg_wr && (reg_addr == A_CTLB);
  assign tx_push = reg_wr && (reg_addr == A_DATA || reg_addr == A_HOLD);
  assign rx_pop  = reg_rd && (reg_addr == A_DATA);
  assign flush   = wr_ctla && reg_wdata[CA_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cpol_q <= 1'b0; launch_q <= 1'b0; capture_q <= 1'b0;
      varlen_q <= 1'b0; speed_q <= '0; flen_q <= '0;
      txe_ie_q <= 1'b0; idle_ie_q <= 1'b0;
    end else begin
      if (wr_ctla) begin
        en_q      <= reg_wdata[CA_EN];
        cpol_q    <= reg_wdata[CA_CPOL];
        launch_q  <= reg_wdata[CA_LAUNCH];
        capture_q <= reg_wdata[CA_CAPTURE];
        varlen_q  <= reg_wdata[CA_VARLEN];
        speed_q   <= reg_wdata[CA_SPD_LSB +: SPEED_W];
        flen_q    <= reg_wdata[CA_FLEN_LSB +: 6];
      end
      if (wr_ctlb) begin
        txe_ie_q  <= reg_wdata[CB_TXE_IE];
        idle_ie_q <= reg_wdata[CB_IDLE_IE];
      end
    end
  end

  // TX path: entry = {hold flag, 32-bit word}
  logic [TXE_W-1:0] tx_head;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty, tx_take;
  logic [PAY_W-1:0] rx_head, rx_word;
  logic             rx_valid, busy;
  logic [5:0]       bits_left;

  vws_fifo #(.WIDTH(TXE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .flush,
    .push(tx_push), .din({reg_addr == A_HOLD, reg_wdata}),
    .pop(tx_take), .dout(tx_head),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  vws_fifo #(.WIDTH(PAY_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .flush,
    .push(rx_valid), .din(rx_word),
    .pop(rx_pop), .dout(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  // entry length: per-entry top byte or the fixed field, clamped to 1..24
  logic [7:0]       raw_len;
  logic [LEN_W-1:0] eff_len;
  assign raw_len = varlen_q ? tx_head[31:24] : {2'b00, flen_q};
  assign eff_len = (raw_len == 8'd0 || raw_len > 8'(PAY_W)) ? LEN_W'(PAY_W) : raw_len[LEN_W-1:0];

  vws_shifter #(.SPEED_W(SPEED_W)) u_shift (
    .clk, .rst_n, .en(en_q), .cpol(cpol_q),
    .launch_lead(launch_q), .capture_trail(capture_q), .speed(speed_q),
    .ent_valid(!tx_empty), .ent_data(tx_head[PAY_W-1:0]),
    .ent_len(eff_len), .ent_hold(tx_head[TXE_W-1]), .ent_take(tx_take),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .busy, .bits_left, .rx_valid, .rx_word);

  assign irq = (txe_ie_q && tx_empty) || (idle_ie_q && !busy);

  logic [31:0] stat_w, ctla_w, ctlb_w;
  always_comb begin
    stat_w        = '0;
    stat_w[31:24] = 8'(tx_lvl);
    stat_w[23:16] = 8'(rx_lvl);
    stat_w[10]    = tx_full;
    stat_w[9]     = tx_empty;
    stat_w[8]     = rx_full;
    stat_w[7]     = rx_empty;
    stat_w[6]     = busy;
    stat_w[5:0]   = bits_left;

    ctla_w = '0;
    ctla_w[CA_EN]      = en_q;
    ctla_w[CA_CPOL]    = cpol_q;
    ctla_w[CA_LAUNCH]  = launch_q;
    ctla_w[CA_CAPTURE] = capture_q;
    ctla_w[CA_VARLEN]  = varlen_q;
    ctla_w[CA_SPD_LSB +: SPEED_W] = speed_q;
    ctla_w[CA_FLEN_LSB +: 6]      = flen_q;

    ctlb_w = '0;
    ctlb_w[CB_TXE_IE]  = txe_ie_q;
    ctlb_w[CB_IDLE_IE] = idle_ie_q;

    case (reg_addr)
      A_CTLA:  reg_rdata = ctla_w;
      A_CTLB:  reg_rdata = ctlb_w;
      A_STAT:  reg_rdata = stat_w;
      A_DATA:  reg_rdata = rx_empty ? 32'd0 : {8'd0, rx_head};
      default: reg_rdata = 32'd0;
    endcase
  end

  p_disable_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !busy);
endmodule

// File: tb/test_vws_spi_master.sv
module test_vws_spi_master;
  import vws_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr, rd, lb, miso_fix;
  logic [2:0]  addr;
  logic [31:0] wdata;
  wire  [31:0] rdata;
  wire         sclk, mosi, cs_n, irq;
  wire         miso = lb ? mosi : miso_fix;

  vws_spi_master i_vws_spi_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n), .irq(irq));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // pin monitor, sampled 5 ns after each rising edge
  int cyc = 0, toggles = 0, last_t = 0, min_gap = 0, max_gap = 0, cs_rises = 0;
  logic sclk_prev = 1'b0, cs_prev = 1'b1;
  always @(posedge clk) begin
    #5;
    cyc++;
    if (sclk !== sclk_prev) begin
      toggles++;
      if (toggles > 1) begin
        if (cyc - last_t < min_gap) min_gap = cyc - last_t;
        if (cyc - last_t > max_gap) max_gap = cyc - last_t;
      end
      last_t = cyc;
    end
    sclk_prev = sclk;
    if (cs_n === 1'b1 && cs_prev === 1'b0) cs_rises++;
    cs_prev = cs_n;
  end

  task automatic clear_mon();
    toggles = 0; min_gap = 1000000; max_gap = 0; cs_rises = 0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    bit ok = 0;
    for (int i = 0; i < 5000 && !ok; i++) begin
      rd_reg(A_STAT, s);
      if (!s[6] && s[9]) ok = 1;
    end
    check({tag, " idle reached"}, 32'(ok), 32'd1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ctla(input logic [11:0] spd, input logic pol,
                                       input logic pha, input logic varl, input logic [5:0] fl);
    return (32'(spd) << 20) | (32'(varl) << 14) | (32'd1 << 11) | (32'(pha) << 10) |
           (32'(pha) << 8) | (32'(pol) << 7) | 32'(fl);
  endfunction

  typedef struct packed {
    logic [11:0] spd;
    logic [1:0]  mode;   // {cpol, phase}
    logic [7:0]  len;
    logic [23:0] data;
    logic [23:0] exp;
    logic [4:0]  elen;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{12'd0, 2'd0, 8'd8,  24'hA50000, 24'hA50000, 5'd8},
    '{12'd1, 2'd1, 8'd12, 24'h123456, 24'h123000, 5'd12},
    '{12'd2, 2'd2, 8'd24, 24'hC35AF0, 24'hC35AF0, 5'd24},
    '{12'd0, 2'd3, 8'd1,  24'hFFFFFF, 24'h800000, 5'd1},
    '{12'd3, 2'd0, 8'd0,  24'h0F0F0F, 24'h0F0F0F, 5'd24},
    '{12'd1, 2'd1, 8'd30, 24'h5A5A5A, 24'h5A5A5A, 5'd24},
    '{12'd0, 2'd0, 8'd5,  24'hFFFFFF, 24'hF80000, 5'd5}
  };

  initial begin
    vec_t t;
    logic [31:0] r;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; lb = 1'b1; miso_fix = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd_reg(A_STAT, r);
    check("R11 status after reset", r, 32'h0000_0280);
    check("R11 cs_n after reset", 32'(cs_n), 32'd1);
    check("R11 sclk after reset", 32'(sclk), 32'd0);
    check("R11 irq after reset", 32'(irq), 32'd0);

    // vector table, MOSI looped back to MISO
    for (int v = 0; v < NV; v++) begin
      t = VECS[v];
      wr_reg(A_CTLA, ctla(t.spd, t.mode[1], t.mode[0], 1'b1, 6'd0));
      clear_mon();
      wr_reg(A_DATA, {t.len, t.data});
      wait_idle("R2");
      rd_reg(A_DATA, r);
      check($sformatf("R1/R5/R6 vec %0d rx word", v), r, {8'd0, t.exp});
      check($sformatf("R2 vec %0d sclk transitions", v), 32'(toggles), 32'(2 * t.elen));
      check($sformatf("R2 vec %0d half period", v), 32'(min_gap), 32'(t.spd) + 1);
      check($sformatf("R4 vec %0d cs released", v), 32'(cs_n), 32'd1);
      check($sformatf("R5 vec %0d sclk idle level", v), 32'(sclk), 32'(t.mode[1]));
    end

    // R3/R4: hold entry followed by data entry forms one frame
    wr_reg(A_CTLA, ctla(12'd1, 1'b0, 1'b0, 1'b1, 6'd0));
    clear_mon();
    wr_reg(A_HOLD, {8'd8, 24'hAA0000});
    wr_reg(A_DATA, {8'd8, 24'h550000});
    wait_idle("R3");
    check("R3 idle gap between entries", 32'(max_gap), 32'd6);
    check("R2 half period in frame", 32'(min_gap), 32'd2);
    check("R4 single cs rise for frame", 32'(cs_rises), 32'd1);
    check("R4 cs high after frame", 32'(cs_n), 32'd1);
    rd_reg(A_DATA, r);
    check("R6 first rx word in order", r, 32'h00AA_0000);
    rd_reg(A_DATA, r);
    check("R6 second rx word in order", r, 32'h0055_0000);

    // R4: hold entry alone leaves cs asserted
    clear_mon();
    wr_reg(A_HOLD, {8'd4, 24'hF00000});
    wait_idle("R4");
    check("R4 cs held low after hold entry", 32'(cs_n), 32'd0);
    check("R4 no cs rise after hold entry", 32'(cs_rises), 32'd0);
    rd_reg(A_DATA, r);
    check("R6 hold entry rx", r, 32'h00F0_0000);
    wr_reg(A_DATA, {8'd4, 24'h000000});
    wait_idle("R4");
    check("R4 cs released by data entry", 32'(cs_n), 32'd1);
    check("R4 one cs rise", 32'(cs_rises), 32'd1);
    rd_reg(A_DATA, r);

    // R1: fixed-width mode ignores the entry's top byte
    wr_reg(A_CTLA, ctla(12'd0, 1'b0, 1'b0, 1'b0, 6'd6));
    clear_mon();
    wr_reg(A_DATA, {8'h03, 24'hABCDEF});
    wait_idle("R1");
    check("R1 fixed width transitions", 32'(toggles), 32'd12);
    rd_reg(A_DATA, r);
    check("R1 fixed width rx word", r, 32'h00A8_0000);

    // R6: captured data comes from MISO, low bits zero
    lb = 1'b0; miso_fix = 1'b1;
    wr_reg(A_CTLA, ctla(12'd0, 1'b0, 1'b0, 1'b1, 6'd0));
    wr_reg(A_DATA, {8'd8, 24'h000000});
    wait_idle("R6");
    rd_reg(A_DATA, r);
    check("R6 rx from miso", r, 32'h00FF_0000);
    lb = 1'b1;

    // R7/R8: RX overflow drops the fifth word
    for (int k = 0; k < 5; k++) wr_reg(A_DATA, {8'd2, 24'hC00000});
    wait_idle("R7");
    rd_reg(A_STAT, r);
    check("R7 rx level capped at 4", 32'(r[23:16]), 32'd4);
    check("R8 rx full flag", 32'(r[8]), 32'd1);

    // R7: TX overflow while disabled
    wr_reg(A_CTLA, 32'd0);
    for (int k = 0; k < 5; k++) wr_reg(A_DATA, {8'd8, 24'h123456});
    rd_reg(A_STAT, r);
    check("R7 tx level capped at 4", 32'(r[31:24]), 32'd4);
    check("R8 tx full flag", 32'(r[10]), 32'd1);
    check("R8 tx empty flag clear", 32'(r[9]), 32'd0);

    // R9 interrupt sources
    wr_reg(A_CTLB, 32'd1 << 6);
    check("R9 irq low with tx pending", 32'(irq), 32'd0);
    wr_reg(A_CTLB, 32'd1 << 7);
    check("R9 irq high when idle", 32'(irq), 32'd1);

    // R10 clear-only write
    wr_reg(A_CTLB, 32'd0);
    wr_reg(A_CTLA, 32'd1 << 9);
    rd_reg(A_STAT, r);
    check("R10 fifos flushed", r, 32'h0000_0280);
    check("R10 irq masked", 32'(irq), 32'd0);
    wr_reg(A_CTLB, 32'd1 << 6);
    check("R9 irq on tx empty", 32'(irq), 32'd1);
    wr_reg(A_CTLB, 32'd0);

    // R6 empty read
    rd_reg(A_DATA, r);
    check("R6 empty read returns zero", r, 32'd0);
    rd_reg(A_STAT, r);
    check("R6 empty read leaves status", r, 32'h0000_0280);

    // R10/R8: disable in mid-transfer
    wr_reg(A_CTLA, ctla(12'd3, 1'b0, 1'b0, 1'b1, 6'd0));
    wr_reg(A_DATA, {8'd24, 24'hFFFFFF});
    repeat (20) @(negedge clk);
    rd_reg(A_STAT, r);
    check("R8 busy during shift", 32'(r[6]), 32'd1);
    check("R8 bits left in range", 32'(r[5:0] >= 6'd1 && r[5:0] <= 6'd24), 32'd1);
    wr_reg(A_CTLA, 32'd0);
    repeat (2) @(negedge clk);
    check("R10 cs released on disable", 32'(cs_n), 32'd1);
    rd_reg(A_STAT, r);
    check("R10 not busy after disable", 32'(r[6]), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule